// File: doc/BRIEF.md
# Three-Wire Configuration and Mode Controller

This block receives an 8-bit configuration word from a host microcontroller over a three-wire serial bus, stores it in a configuration register, and turns it into power-enable signals for the analog sections of a low-frequency FSK transceiver. The bus has three lines: a bit clock, a data line and an enable line. A transfer opens when the enable line rises. Data is taken on the falling edges of the bit clock. The register is written in one step, and only once all eight bits have arrived.

One register flag, the transmit flag, is combined with an external receive-request pin to choose one of four operating modes: standby, carrier detect, transmit and receive. For each mode the block drives enables for the receiver, transmitter, carrier detector, PLL and reference block. The oscillator enable follows its own register flag. The carrier select, the detector threshold select, the 3-bit power code and the test flag are also driven out. All bus and pin inputs are synchronised into the system clock domain. Every output is registered.

Top module: `three_wire_mode_ctrl`

## Requirements
- R1: While `rst` is high, and after it, the configuration register holds all zeros and every output is 0 until a complete word is received.
- R2: A transfer opens on a rising edge of `bus_sen_i`. `bus_sdat_i` is sampled on each falling edge of `bus_sclk_i` that follows. The first bit sampled lands in register bit 0 and the eighth in bit 7.
- R3: Once eight bits have been captured, further falling edges of `bus_sclk_i` are ignored until `bus_sen_i` rises again.
- R4: A transfer whose `bus_sen_i` falls in the same instant as the eighth falling edge of `bus_sclk_i` still commits all eight bits.
- R5: If `bus_sen_i` falls before eight bits have been captured, the transfer is dropped and the register keeps its previous value.
- R6: `mode_o` = {register bit 1, `rx_req_i`}: 0 = standby, 1 = carrier detect, 2 = transmit, 3 = receive.
- R7: In standby, receiver, transmitter, carrier detector, PLL and reference enables are all 0. Carrier detect enables the carrier detector and reference. Transmit enables the transmitter, PLL and reference. Receive enables the receiver, PLL and reference.
- R8: `osc_en_o` equals register bit 7 in every mode, standby included.
- R9: `carrier_sel_o` = bit 0, `pwr_code_o` = bits 4:2 (bit 2 is the LSB), `thresh_sel_o` = bit 5, `test_mode_o` = bit 6.
- R10: Falling edges of `bus_sclk_i` while `bus_sen_i` is low leave the register unchanged.
- R11: The outputs do not change while a transfer is in progress. Writing 00000000 with `rx_req_i` low returns the block to standby with every enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sclk_i | input | 1 | Serial bit clock; data taken on its falling edge |
| bus_sdat_i | input | 1 | Serial data, first bit goes to register bit 0 |
| bus_sen_i | input | 1 | Transfer enable; rising edge opens a transfer |
| rx_req_i | input | 1 | Receive-request pin, combined with the transmit flag |
| mode_o | output | 2 | Decoded operating mode |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| cdet_en_o | output | 1 | Carrier detector enable |
| pll_en_o | output | 1 | PLL enable |
| ref_en_o | output | 1 | Reference block enable |
| osc_en_o | output | 1 | Oscillator enable |
| carrier_sel_o | output | 1 | Carrier frequency select |
| thresh_sel_o | output | 1 | Carrier detector threshold select |
| pwr_code_o | output | 3 | Transmit power code |
| test_mode_o | output | 1 | Test flag |

## Verification
Two events can land in the same system-clock cycle: the capture of the last bit, which commits the word, and the fall of the enable line, which would otherwise abort the transfer. The bench drives `bus_sen_i` low in the same instant as the eighth falling clock edge. Both lines pass through synchronisers of equal depth, so the block sees the two events in one cycle. The check passes only if the mode, oscillator enable and carrier select afterwards all match the full eight-bit word. A transfer that is cut off after five bits is then run to confirm that the same drop of the enable line discards a partial word.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int CFG_BITS = 8;
  localparam int FC_POS   = 0;
  localparam int TR_POS   = 1;
  localparam int PWR_LSB  = 2;
  localparam int PWR_W    = 3;
  localparam int SENS_POS = 5;
  localparam int TEST_POS = 6;
  localparam int OSC_POS  = 7;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_CDET = 2'b01,
    MODE_TX   = 2'b10,
    MODE_RX   = 2'b11
  } mode_e;

  typedef struct packed {
    logic rx;
    logic tx;
    logic cd;
    logic pll;
    logic refb;
    logic osc;
  } enables_t;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/twm_capture.sv
module twm_capture #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sc_i,
  input  logic             sd_i,
  input  logic             de_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int CNT_W = $clog2(CFG_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_W - 1);

  logic             sc_q, de_q, active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] shift_q, cfg_q;
  logic             sc_fall, de_rise, take, take_last;

  assign sc_fall   = sc_q & ~sc_i;
  assign de_rise   = ~de_q & de_i;
  assign take      = active_q & sc_fall;
  assign take_last = take && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_q     <= 1'b0;
      de_q     <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
      cfg_q    <= '0;
    end else begin
      sc_q <= sc_i;
      de_q <= de_i;
      if (de_rise) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (take) begin
        shift_q <= {sd_i, shift_q[CFG_W-1:1]};
        cnt_q   <= cnt_q + 1'b1;
        if (take_last) begin
          cfg_q    <= {sd_i, shift_q[CFG_W-1:1]};
          active_q <= 1'b0;
        end else if (!de_i) begin
          active_q <= 1'b0;
        end
      end else if (!de_i) begin
        active_q <= 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;

  // R3
  stop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    take_last |=> !active_q);

  // R11
  atomic_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !take_last |=> $stable(cfg_q));
endmodule

// File: rtl/twm_decode.sv
module twm_decode
  import twm_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             re_i,
  output logic [1:0]       mode_o,
  output enables_t         en_o,
  output logic             carrier_o,
  output logic             thresh_o,
  output logic [PWR_W-1:0] pwr_o,
  output logic             test_o
);
  mode_e    mode_d;
  enables_t en_d;

  always_comb begin
    mode_d = mode_e'({cfg_i[TR_POS], re_i});
    en_d   = '0;
    unique case (mode_d)
      MODE_IDLE: ;
      MODE_CDET: begin en_d.cd = 1'b1; en_d.refb = 1'b1; end
      MODE_TX:   begin en_d.tx = 1'b1; en_d.pll = 1'b1; en_d.refb = 1'b1; end
      MODE_RX:   begin en_d.rx = 1'b1; en_d.pll = 1'b1; en_d.refb = 1'b1; end
      default: ;
    endcase
    en_d.osc = cfg_i[OSC_POS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= '0;
      en_o      <= '0;
      carrier_o <= 1'b0;
      thresh_o  <= 1'b0;
      pwr_o     <= '0;
      test_o    <= 1'b0;
    end else begin
      mode_o    <= mode_d;
      en_o      <= en_d;
      carrier_o <= cfg_i[FC_POS];
      thresh_o  <= cfg_i[SENS_POS];
      pwr_o     <= cfg_i[PWR_LSB +: PWR_W];
      test_o    <= cfg_i[TEST_POS];
    end
  end

  // R7
  one_block_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_o.rx, en_o.tx, en_o.cd}));

  // R7
  pll_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    en_o.pll |-> en_o.refb);

  // R7
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00) |-> !(en_o.pll || en_o.refb || en_o.cd));

  // R8
  osc_track_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (en_o.osc == $past(cfg_i[OSC_POS])));
endmodule

// File: rtl/three_wire_mode_ctrl.sv
module three_wire_mode_ctrl
  import twm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = CFG_BITS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sclk_i,
  input  logic       bus_sdat_i,
  input  logic       bus_sen_i,
  input  logic       rx_req_i,
  output logic [1:0] mode_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       cdet_en_o,
  output logic       pll_en_o,
  output logic       ref_en_o,
  output logic       osc_en_o,
  output logic       carrier_sel_o,
  output logic       thresh_sel_o,
  output logic [2:0] pwr_code_o,
  output logic       test_mode_o
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] pins_s;
  logic [CFG_W-1:0] cfg;
  enables_t         en;

  twm_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({rx_req_i, bus_sen_i, bus_sdat_i, bus_sclk_i}),
    .q_o (pins_s)
  );

  twm_capture #(.CFG_W(CFG_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .sc_i  (pins_s[0]),
    .sd_i  (pins_s[1]),
    .de_i  (pins_s[2]),
    .cfg_o (cfg)
  );

  twm_decode #(.CFG_W(CFG_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cfg_i     (cfg),
    .re_i      (pins_s[3]),
    .mode_o    (mode_o),
    .en_o      (en),
    .carrier_o (carrier_sel_o),
    .thresh_o  (thresh_sel_o),
    .pwr_o     (pwr_code_o),
    .test_o    (test_mode_o)
  );

  assign rx_en_o   = en.rx;
  assign tx_en_o   = en.tx;
  assign cdet_en_o = en.cd;
  assign pll_en_o  = en.pll;
  assign ref_en_o  = en.refb;
  assign osc_en_o  = en.osc;
endmodule

// File: tb/tb_three_wire_mode_ctrl.sv
`timescale 1ns/1ps
module tb_three_wire_mode_ctrl;
  localparam int HOLD = 4;
  localparam int NVEC = 8;
  // word, receive-request, expected {rx,tx,cd,pll,ref,osc}
  localparam logic [7:0] VW  [NVEC] = '{8'h00, 8'h00, 8'h02, 8'h02, 8'h80, 8'hA5, 8'h5E, 8'hFF};
  localparam logic       VRE [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [5:0] VEN [NVEC] = '{6'b000000, 6'b001010, 6'b010110, 6'b100110,
                                        6'b000001, 6'b001011, 6'b010110, 6'b100111};

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, sdat = 1'b0, sen = 1'b0, rxreq = 1'b0;
  logic [1:0] mode;
  logic rx_en, tx_en, cd_en, pll_en, ref_en, osc_en, car, thr, tst;
  logic [2:0] pwr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  three_wire_mode_ctrl dut (
    .clk(clk), .rst(rst), .bus_sclk_i(sclk), .bus_sdat_i(sdat), .bus_sen_i(sen),
    .rx_req_i(rxreq), .mode_o(mode), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .cdet_en_o(cd_en), .pll_en_o(pll_en), .ref_en_o(ref_en), .osc_en_o(osc_en),
    .carrier_sel_o(car), .thresh_sel_o(thr), .pwr_code_o(pwr), .test_mode_o(tst)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] en_vec();
    return {rx_en, tx_en, cd_en, pll_en, ref_en, osc_en};
  endfunction

  task automatic bit_out(input logic b, input bit drop_de);
    sdat = b; cyc(HOLD);
    sclk = 1'b0;
    if (drop_de) sen = 1'b0;
    cyc(HOLD);
    sclk = 1'b1; cyc(HOLD);
  endtask

  task automatic xfer(input logic [7:0] w, input int nbits, input bit fall_last, input int extra);
    sen = 1'b1; cyc(HOLD);
    for (int i = 0; i < nbits; i++) bit_out(w[i], fall_last && (i == nbits - 1));
    for (int k = 0; k < extra; k++) bit_out(~w[k], 1'b0);
    sen = 1'b0; cyc(HOLD);
  endtask

  task automatic settle_sample();
    cyc(10);
    @(negedge clk);
  endtask

  task automatic check_fields(input string req, input logic [7:0] w);
    check(req, {7'd0, car}, {7'd0, w[0]});
    check(req, {5'd0, pwr}, {5'd0, w[4:2]});
    check(req, {7'd0, thr}, {7'd0, w[5]});
    check(req, {7'd0, tst}, {7'd0, w[6]});
  endtask

  initial begin
    cyc(3);
    @(negedge clk);
    // R1 during reset
    check("R1", {2'd0, en_vec()}, 8'h00);
    check("R1", {6'd0, mode}, 8'h00);
    rst = 1'b0;
    settle_sample();
    // R1 after reset
    check("R1", {2'd0, en_vec()}, 8'h00);
    check_fields("R1", 8'h00);

    // table walk: R2, R6, R7, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      rxreq = VRE[v];
      xfer(VW[v], 8, 1'b0, 0);
      settle_sample();
      check("R6", {6'd0, mode}, {6'd0, VW[v][1], VRE[v]});
      check("R7", {2'd0, en_vec()}, {2'd0, VEN[v]});
      check("R8", {7'd0, osc_en}, {7'd0, VW[v][7]});
      check_fields("R2/R9", VW[v]);
    end

    // R3: extra edges after the eighth bit carry inverted data
    rxreq = 1'b0;
    xfer(8'h3C, 8, 1'b0, 4);
    settle_sample();
    check_fields("R3", 8'h3C);
    check("R3", {6'd0, mode}, 8'h00);

    // R4: enable drops in the same instant as the eighth falling edge
    xfer(8'h83, 8, 1'b1, 0);
    settle_sample();
    check("R4", {6'd0, mode}, 8'h02);
    check("R4", {7'd0, osc_en}, 8'h01);
    check("R4", {7'd0, car}, 8'h01);

    // R10: clock edges with enable low are ignored
    for (int k = 0; k < 8; k++) bit_out(1'b0, 1'b0);
    settle_sample();
    check("R10", {6'd0, mode}, 8'h02);
    check("R10", {2'd0, en_vec()}, 8'b00010111);

    // R5: transfer cut off after five bits
    xfer(8'h00, 5, 1'b0, 0);
    settle_sample();
    check("R5", {6'd0, mode}, 8'h02);
    check("R5", {7'd0, osc_en}, 8'h01);
    check("R5", {7'd0, car}, 8'h01);

    // R11: mid-transfer outputs hold, then zero word returns to standby
    sen = 1'b1; cyc(HOLD);
    for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
    settle_sample();
    check("R11", {2'd0, en_vec()}, 8'b00010111);
    for (int i = 4; i < 8; i++) bit_out(1'b0, 1'b0);
    sen = 1'b0;
    settle_sample();
    check("R11", {2'd0, en_vec()}, 8'h00);
    check("R11", {6'd0, mode}, 8'h00);

    // R1: reset in operation clears the register
    rxreq = 1'b1;
    xfer(8'hFF, 8, 1'b0, 0);
    settle_sample();
    check("R7", {2'd0, en_vec()}, 8'b00100111);
    rst = 1'b1; cyc(2);
    rst = 1'b0; rxreq = 1'b0;
    settle_sample();
    check("R1", {2'd0, en_vec()}, 8'h00);
    check_fields("R1", 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule